// File: doc/BRIEF.md
# Ternary-Weight Streaming Dot-Product Accumulator

This block forms the dot product of a stream of signed integer activations with a stream of weights that take only the values -1, 0 and +1. It has no multiplier. Each weight selects one of three contributions through a multiplexer: the activation itself, its two's-complement negation (built from a bitwise inversion and a carry-in into the adder), or nothing. An element with a zero weight does not update the sum at all.

One element arrives per cycle on a valid/ready handshake. The element is an activation, a two-bit weight code, a start flag and a last flag. Start discards the old sum and begins a new vector with the element that carries it. Last closes the vector. The block then presents the sum, a count of the zero-weight elements in the vector, and a sticky flag for illegal weight codes. These outputs stay until a consumer takes them. A parameter picks whether sums beyond the accumulator range clamp or wrap.

The controller has two states. In `ST_GATHER` elements are accepted. In `ST_OFFER` the result is presented and input is stalled. Transition `T_CLOSE` goes from `ST_GATHER` to `ST_OFFER` when an element flagged last is accepted. Transition `T_TAKEN` goes from `ST_OFFER` back to `ST_GATHER` when the consumer raises its ready. Every other case keeps the current state.

Top module: `ternary_dot_acc`

## Requirements
- R1: Weight code 2 (+1) adds the sign-extended activation to the running sum.
- R2: Weight code 1 (-1) adds the two's-complement negation of the activation, so -128 contributes +128 at the default 8-bit width.
- R3: Weight code 0 leaves the sum unchanged and increments the per-vector zero-weight count `res_zeros`.
- R4: Weight code 3 is illegal. It leaves the sum and the zero count unchanged and sets `res_bad_code`, which stays set until the next accepted start element. An illegal code on a start element leaves the flag set.
- R5: An accepted element with start asserted clears the sum, the zero count and the error flag in the same cycle, and its own contribution is included. Without start, a new vector continues from the previous sum.
- R6: The cycle after an element flagged last is accepted, `res_valid` is 1 and `in_ready` is 0. The result holds unchanged until a cycle in which `res_ready` is 1, and on the cycle after that `res_valid` is 0 and `in_ready` is 1.
- R7: With the default ACC_W (ACT_W + ceil(log2(MAX_LEN)) + 1 bits), a vector of MAX_LEN elements at the extreme activation -128, with either nonzero weight, gives the exact sum (+8192 or -8192 at defaults).
- R8: When the sum goes beyond the accumulator range, SATURATE=1 clamps to the largest or smallest value (+16383 / -16384 at defaults), and SATURATE=0 wraps modulo 2^ACC_W.
- R9: After reset, `in_ready` is 1, `res_valid` is 0, and the sum, zero count and error flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Element offered |
| in_ready | output | 1 | Element can be accepted (state `ST_GATHER`) |
| in_act | input | ACT_W | Signed activation |
| in_wcode | input | 2 | Weight code: 0 zero, 1 minus one, 2 plus one, 3 illegal |
| in_start | input | 1 | Element opens a new vector |
| in_last | input | 1 | Element closes the vector |
| res_valid | output | 1 | Result presented (state `ST_OFFER`) |
| res_ready | input | 1 | Consumer takes the result |
| res_sum | output | ACC_W | Signed dot-product sum |
| res_zeros | output | CNT_W | Zero-weight elements in the vector |
| res_bad_code | output | 1 | Sticky illegal-code flag |

## Verification
The start clear and the close of a vector can fall on the same element. An illegal code can fall on that element too, so the flag is cleared and set in one cycle. The bench sends one-element vectors that carry start and last together. It does this with a legal code and with code 3. It then checks that the result equals that element's contribution alone and that the error flag follows the rule that setting wins. Accumulation and result hand-off never overlap, because input is stalled in `ST_OFFER`. Holding `res_ready` low for several cycles tests this stall.

// File: rtl/tdot_pkg.sv
package tdot_pkg;

    typedef enum logic [1:0] {
        W_ZERO = 2'd0,
        W_NEG  = 2'd1,
        W_POS  = 2'd2,
        W_BAD  = 2'd3
    } wcode_t;

    typedef enum logic {
        ST_GATHER = 1'b0,
        ST_OFFER  = 1'b1
    } phase_t;

    // Smallest accumulator that holds len terms of magnitude 2^(aw-1).
    function automatic int min_acc_w(input int aw, input int len);
        return aw + $clog2(len) + 1;
    endfunction

endpackage

// File: rtl/tdot_select.sv
module tdot_select
    import tdot_pkg::*;
#(
    parameter int ACT_W = 8,
    parameter int ACC_W = 15
) (
    input  logic [ACT_W-1:0] act,
    input  logic [1:0]       code,
    output logic [ACC_W-1:0] addend,
    output logic             carry_in,
    output logic             apply,
    output logic             zero_w,
    output logic             bad_w
);
    localparam int EXT_W = ACC_W - ACT_W;

    logic [ACC_W-1:0] ext;
    logic             invert;

    assign ext = {{EXT_W{act[ACT_W-1]}}, act};

    always_comb begin
        invert = 1'b0;
        apply  = 1'b0;
        zero_w = 1'b0;
        bad_w  = 1'b0;
        unique case (wcode_t'(code))
            W_ZERO: zero_w = 1'b1;
            W_NEG: begin
                invert = 1'b1;
                apply  = 1'b1;
            end
            W_POS:  apply  = 1'b1;
            W_BAD:  bad_w  = 1'b1;
        endcase
    end

    // Negation as inversion plus carry-in to the adder.
    assign addend   = ext ^ {ACC_W{invert}};
    assign carry_in = invert;

endmodule

// File: rtl/tdot_adder.sv
module tdot_adder #(
    parameter int ACC_W    = 15,
    parameter bit SATURATE = 1'b1
) (
    input  logic [ACC_W-1:0] base,
    input  logic [ACC_W-1:0] addend,
    input  logic             carry_in,
    output logic [ACC_W-1:0] result
);
    localparam int WIDE_W = ACC_W + 1;

    logic [WIDE_W-1:0] wide;
    logic              ovf;

    assign wide = {base[ACC_W-1], base} + {addend[ACC_W-1], addend}
                + {{ACC_W{1'b0}}, carry_in};
    assign ovf  = wide[ACC_W] ^ wide[ACC_W-1];

    generate
        if (SATURATE) begin : g_clamp
            always_comb begin
                if (!ovf)
                    result = wide[ACC_W-1:0];
                else if (wide[ACC_W])
                    result = {1'b1, {(ACC_W-1){1'b0}}};
                else
                    result = {1'b0, {(ACC_W-1){1'b1}}};
            end
        end else begin : g_wrap
            assign result = wide[ACC_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/tdot_ctrl.sv
module tdot_ctrl
    import tdot_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_last,
    input  logic res_ready,
    output logic in_ready,
    output logic res_valid,
    output logic accept
);
    phase_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_GATHER;
        else
            state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_GATHER: if (in_valid && in_last) state_nx = ST_OFFER;  // T_CLOSE
            ST_OFFER:  if (res_ready)           state_nx = ST_GATHER; // T_TAKEN
        endcase
    end

    always_comb begin
        in_ready  = 1'b0;
        res_valid = 1'b0;
        unique case (state)
            ST_GATHER: in_ready  = 1'b1;
            ST_OFFER:  res_valid = 1'b1;
        endcase
    end

    assign accept = in_valid && in_ready;

endmodule

// File: rtl/ternary_dot_acc.sv
module ternary_dot_acc
    import tdot_pkg::*;
#(
    parameter int ACT_W    = 8,
    parameter int MAX_LEN  = 64,
    parameter int ACC_W    = min_acc_w(ACT_W, MAX_LEN),
    parameter bit SATURATE = 1'b1,
    parameter int CNT_W    = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [ACT_W-1:0] in_act,
    input  logic [1:0]       in_wcode,
    input  logic             in_start,
    input  logic             in_last,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [ACC_W-1:0] res_sum,
    output logic [CNT_W-1:0] res_zeros,
    output logic             res_bad_code
);
    localparam logic [CNT_W-1:0] ZCNT_MAX = {CNT_W{1'b1}};

    logic             accept;
    logic [ACC_W-1:0] addend, base, summed;
    logic             carry_in, apply, zero_w, bad_w;
    logic [ACC_W-1:0] acc_q;
    logic [CNT_W-1:0] zeros_q, zeros_base;
    logic             bad_q;

    tdot_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .res_ready (res_ready),
        .in_ready  (in_ready),
        .res_valid (res_valid),
        .accept    (accept)
    );

    tdot_select #(.ACT_W(ACT_W), .ACC_W(ACC_W)) u_sel (
        .act      (in_act),
        .code     (in_wcode),
        .addend   (addend),
        .carry_in (carry_in),
        .apply    (apply),
        .zero_w   (zero_w),
        .bad_w    (bad_w)
    );

    assign base       = in_start ? '0 : acc_q;
    assign zeros_base = in_start ? '0 : zeros_q;

    tdot_adder #(.ACC_W(ACC_W), .SATURATE(SATURATE)) u_add (
        .base     (base),
        .addend   (addend),
        .carry_in (carry_in),
        .result   (summed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q   <= '0;
            zeros_q <= '0;
            bad_q   <= 1'b0;
        end else if (accept) begin
            acc_q   <= apply ? summed : base;
            zeros_q <= (zero_w && zeros_base != ZCNT_MAX) ? zeros_base + 1'b1
                                                          : zeros_base;
            bad_q   <= (bad_q && !in_start) || bad_w;
        end
    end

    assign res_sum      = acc_q;
    assign res_zeros    = zeros_q;
    assign res_bad_code = bad_q;

endmodule

// File: rtl/ternary_dot_acc_chk.sv
module ternary_dot_acc_chk #(
    parameter int ACT_W = 8,
    parameter int ACC_W = 15,
    parameter int CNT_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [1:0]       in_wcode,
    input logic             in_start,
    input logic             in_last,
    input logic             res_valid,
    input logic             res_ready,
    input logic [ACC_W-1:0] res_sum,
    input logic [CNT_W-1:0] res_zeros,
    input logic             res_bad_code
);
    logic acc_en;
    assign acc_en = in_valid && in_ready;

    p_skip_sum_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && in_wcode == 2'd0 && !in_start |=> $stable(res_sum));

    p_bad_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && in_wcode == 2'd3 |=> res_bad_code);

    p_bad_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && in_wcode == 2'd3 && !in_start |=> $stable(res_sum) && $stable(res_zeros));

    p_start_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && in_start && in_wcode == 2'd0 |=> res_sum == '0 && res_zeros == 1);

    p_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en && in_last |=> res_valid && !in_ready);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready |=> res_valid && $stable(res_sum) && $stable(res_bad_code));

    p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && in_ready));

endmodule

bind ternary_dot_acc ternary_dot_acc_chk #(
    .ACT_W(ACT_W), .ACC_W(ACC_W), .CNT_W(CNT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .in_wcode     (in_wcode),
    .in_start     (in_start),
    .in_last      (in_last),
    .res_valid    (res_valid),
    .res_ready    (res_ready),
    .res_sum      (res_sum),
    .res_zeros    (res_zeros),
    .res_bad_code (res_bad_code)
);

// File: tb/test_ternary_dot_acc.sv
`timescale 1ns/1ps
module test_ternary_dot_acc;
    localparam int ACT_W = 8;
    localparam int ACC_W = 15;
    localparam int CNT_W = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_start = 1'b0, in_last = 1'b0, res_ready = 1'b0;
    logic [ACT_W-1:0] in_act = '0;
    logic [1:0] in_wcode = '0;
    logic in_ready, res_valid, res_bad_code;
    logic in_ready_w, res_valid_w, res_bad_code_w;
    logic [ACC_W-1:0] res_sum, res_sum_w;
    logic [CNT_W-1:0] res_zeros, res_zeros_w;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ternary_dot_acc #(.ACT_W(ACT_W), .MAX_LEN(64), .SATURATE(1'b1)) i_ternary_dot_acc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_act(in_act), .in_wcode(in_wcode), .in_start(in_start), .in_last(in_last),
        .res_valid(res_valid), .res_ready(res_ready), .res_sum(res_sum),
        .res_zeros(res_zeros), .res_bad_code(res_bad_code));

    ternary_dot_acc #(.ACT_W(ACT_W), .MAX_LEN(64), .SATURATE(1'b0)) i_ternary_dot_acc_wrap (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_w),
        .in_act(in_act), .in_wcode(in_wcode), .in_start(in_start), .in_last(in_last),
        .res_valid(res_valid_w), .res_ready(res_ready), .res_sum(res_sum_w),
        .res_zeros(res_zeros_w), .res_bad_code(res_bad_code_w));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint ssum(input logic [ACC_W-1:0] v);
        return longint'($signed(v));
    endfunction

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic push(input int a, input int code, input bit st, input bit ls);
        in_act   = ACT_W'(a);
        in_wcode = 2'(code);
        in_start = st;
        in_last  = ls;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_start = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic expect_result(input string req, input longint sum, input int zeros, input bit err);
        check(res_valid == 1'b1, req, res_valid, 1);
        check(ssum(res_sum) == sum, req, ssum(res_sum), sum);
        check(res_zeros == CNT_W'(zeros), req, res_zeros, zeros);
        check(res_bad_code == err, req, res_bad_code, err);
    endtask

    task automatic take();
        res_ready = 1'b1;
        @(negedge clk);
        res_ready = 1'b0;
        check(res_valid == 1'b0 && in_ready == 1'b1, "R6 release", res_valid, 0);
    endtask

    task automatic t_reset();
        check(in_ready == 1'b1, "R9 in_ready", in_ready, 1);
        check(res_valid == 1'b0, "R9 res_valid", res_valid, 0);
        check(res_sum == '0 && res_zeros == '0, "R9 sum", ssum(res_sum), 0);
        check(res_bad_code == 1'b0, "R9 err", res_bad_code, 0);
    endtask

    task automatic t_mixed();
        // R1 R2 R3: 5 + 3 + 0 + 100 + 128 = 236, one zero weight
        push(5, 2, 1, 0);
        push(-3, 1, 0, 0);
        push(7, 0, 0, 0);
        push(100, 2, 0, 0);
        push(-128, 1, 0, 1);
        expect_result("R1 R2 R3 mixed", 236, 1, 0);
        take();
        // R1 negative activations with +1, R2 positive with -1
        push(-50, 2, 1, 0);
        push(20, 1, 0, 0);
        push(0, 0, 0, 0);
        push(9, 0, 0, 1);
        expect_result("R1 R2 R3 signs", -70, 2, 0);
        take();
    endtask

    task automatic t_illegal();
        push(10, 2, 1, 0);
        push(20, 3, 0, 0);
        push(4, 1, 0, 1);
        expect_result("R4 ignored", 6, 0, 1);
        take();
        push(3, 2, 1, 1);
        expect_result("R4 cleared by start", 3, 0, 0);
        take();
        // start, last and illegal code on one element
        push(9, 3, 1, 1);
        expect_result("R4 R5 start+bad", 0, 0, 1);
        take();
    endtask

    task automatic t_start();
        push(7, 2, 1, 1);
        expect_result("R5 single", 7, 0, 0);
        take();
        push(1, 2, 0, 1);
        expect_result("R5 continue", 8, 0, 0);
        take();
        push(-2, 1, 1, 1);
        expect_result("R5 clear", 2, 0, 0);
        take();
    endtask

    task automatic t_hold();
        push(11, 2, 1, 0);
        push(4, 2, 0, 1);
        for (int i = 0; i < 5; i++) begin
            check(res_valid && !in_ready, "R6 stall", res_valid, 1);
            check(ssum(res_sum) == 15, "R6 hold sum", ssum(res_sum), 15);
            @(negedge clk);
        end
        take();
    endtask

    task automatic t_extremes();
        for (int i = 0; i < 64; i++) push(-128, 1, i == 0, i == 63);
        expect_result("R7 max positive", 8192, 0, 0);
        take();
        for (int i = 0; i < 64; i++) push(-128, 2, i == 0, i == 63);
        expect_result("R7 max negative", -8192, 0, 0);
        take();
    endtask

    task automatic t_overflow();
        for (int i = 0; i < 200; i++) push(-128, 1, i == 0, i == 199);
        check(ssum(res_sum) == 16383, "R8 sat high", ssum(res_sum), 16383);
        check(ssum(res_sum_w) == -7168, "R8 wrap high", ssum(res_sum_w), -7168);
        take();
        for (int i = 0; i < 200; i++) push(127, 1, i == 0, i == 199);
        check(ssum(res_sum) == -16384, "R8 sat low", ssum(res_sum), -16384);
        check(ssum(res_sum_w) == 7368, "R8 wrap low", ssum(res_sum_w), 7368);
        take();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mixed();
        t_illegal();
        t_start();
        t_hold();
        t_extremes();
        t_overflow();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule